// File: doc/BRIEF.md
# Auxiliary-Channel to I2C Transaction Bridge

This block takes request-level transactions from a display auxiliary channel and carries them out either on a small native register space or on a byte-level I2C master port. A request has a 4-bit command, a 20-bit address, a byte count and a data buffer. The buffer sits outside the block. The bridge reads write bytes from the buffer by index and returns read bytes through a write strobe. When the request is finished, the bridge issues one reply code.

Plain I2C requests are complete transfers: the bridge sends START, moves the bytes, then sends STOP. Middle-of-transaction requests leave the I2C link open between requests. The bridge remembers the address and command of the last open transfer. It inserts a STOP and a new START only when a request changes either of them. The physical line coding of the channel is handled elsewhere.

Top module: `aux_i2c_bridge`

## Requirements
- R1: While reset is held and after it is released, req_ready is 1 and rsp_valid, link_open, i2c_req and reg_req are 0.
- R2: Command codes are 4'b1000 native write, 4'b1001 native read, 4'b0000 I2C write, 4'b0001 I2C read, 4'b0100 open-ended I2C write and 4'b0101 open-ended I2C read. Any other code replies NACK, makes no register or I2C access, and leaves link_open unchanged.
- R3: Reply codes on rsp_code are 2'b00 ACK, 2'b01 NACK, 2'b10 I2C-ACK and 2'b11 I2C-NACK. rsp_valid is a one-cycle pulse, and req_ready is 1 in the cycle after it.
- R4: A native request makes len register accesses at req_addr, req_addr+1 and so on. A read stores byte i at buffer index i. A write sends buffer byte i. When every access is accepted, the reply is ACK, and this includes len 0.
- R5: In a native request, the first access that reg_err refuses ends the request with NACK. No further register access follows it.
- R6: A plain I2C request issues STOP first if the link is open, then START with i2c_addr = req_addr[6:0] and i2c_rd = cmd[0]. If the START is NAKed, the reply is I2C-NACK, no STOP is issued, and the link stays closed.
- R7: After an acknowledged START, a plain request moves len bytes (SEND from the buffer, RECV into the buffer) and stops at the first NAKed byte. It always ends with STOP. The reply is I2C-ACK when all len bytes completed and I2C-NACK otherwise.
- R8: An open-ended request on a closed link issues START. On an open link with the same address and command as the last open transfer, it issues neither STOP nor START. On an open link where either the address or the command differs, it issues STOP and then START.
- R9: An open-ended request that moves all its bytes replies I2C-ACK and leaves link_open at 1, and this includes len 0. A NAKed byte causes a STOP and the reply I2C-NACK. A NAKed START replies I2C-NACK with the link closed.
- R10: i2c_req stays asserted with a stable i2c_op until i2c_done. i2c_op codes are 0 START, 1 SEND, 2 RECV and 3 STOP. START is never issued while link_open is 1, and reg_req and i2c_req are never 1 together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Bridge idle, request taken when valid |
| req_cmd | input | 4 | Request command code |
| req_addr | input | 20 | Request address |
| req_len | input | 5 | Byte count (0 to 16) |
| rsp_valid | output | 1 | Reply pulse |
| rsp_code | output | 2 | Reply code |
| buf_idx | output | 5 | Current data buffer index |
| buf_rdata | input | 8 | Buffer byte at buf_idx (write data) |
| buf_wr | output | 1 | Store buf_wdata at buf_idx |
| buf_wdata | output | 8 | Read byte to store |
| reg_req | output | 1 | Native register access |
| reg_we | output | 1 | Native access is a write |
| reg_addr | output | 20 | Native register address |
| reg_wdata | output | 8 | Native write byte |
| reg_rdata | input | 8 | Native read byte, same cycle |
| reg_err | input | 1 | Native access refused, same cycle |
| i2c_req | output | 1 | I2C operation pending |
| i2c_op | output | 2 | I2C operation code |
| i2c_addr | output | 7 | I2C target address for START |
| i2c_rd | output | 1 | Direction for START |
| i2c_wdata | output | 8 | Byte for SEND |
| i2c_done | input | 1 | Operation complete |
| i2c_nak | input | 1 | Operation not acknowledged, valid with done |
| i2c_rdata | input | 8 | Byte from RECV, valid with done |
| link_open | output | 1 | An I2C transfer is open |

## Verification
In the dispatch cycle of an open-ended request, two things are settled together: the comparison with the last tracked address and command, and the choice between continuing the open transfer and restarting it. When the request continues, the tracker is updated in that same cycle. The bench sends back-to-back open-ended requests that keep both fields, that change only the command, and that change only the address. It judges each request by how many STARTs, STOPs and bytes appear on the I2C port and by the state of link_open afterwards. Requests that would leave stale state are placed next to these: a plain request while a transfer is open, and a request with an unsupported command.

// File: rtl/aux_bridge_pkg.sv
package aux_bridge_pkg;

    typedef enum logic [1:0] {
        RSP_ACK      = 2'b00,
        RSP_NACK     = 2'b01,
        RSP_I2C_ACK  = 2'b10,
        RSP_I2C_NACK = 2'b11
    } rsp_e;

    typedef enum logic [1:0] {
        OP_START = 2'd0,
        OP_SEND  = 2'd1,
        OP_RECV  = 2'd2,
        OP_STOP  = 2'd3
    } i2c_op_e;

    typedef enum logic [1:0] {
        K_BAD    = 2'd0,
        K_NATIVE = 2'd1,
        K_PLAIN  = 2'd2,
        K_OPEN   = 2'd3
    } kind_e;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_DISPATCH,
        ST_NATIVE,
        ST_PRE_END,
        ST_START,
        ST_XFER,
        ST_POST_END,
        ST_REPLY
    } state_e;

    localparam logic [3:0] CMD_INVALID = 4'hF;

endpackage

// File: rtl/aux_cmd_decode.sv
module aux_cmd_decode
    import aux_bridge_pkg::*;
(
    input  logic [3:0] cmd,
    output kind_e      kind,
    output logic       is_read
);
    // bit3 selects the register space, bit2 the open-ended I2C form,
    // bit0 the direction; bit1 is never set in a supported code
    always_comb begin
        is_read = cmd[0];
        if (cmd[1]) begin
            kind = K_BAD;
        end else if (cmd[3]) begin
            kind = cmd[2] ? K_BAD : K_NATIVE;
        end else begin
            kind = cmd[2] ? K_OPEN : K_PLAIN;
        end
    end
endmodule

// File: rtl/aux_open_track.sv
module aux_open_track
    import aux_bridge_pkg::*;
#(
    parameter int ADDR_W = 20
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              upd,
    input  logic [ADDR_W-1:0] cur_addr,
    input  logic [3:0]        cur_cmd,
    output logic              differ
);
    typedef struct packed {
        logic [ADDR_W-1:0] addr;
        logic [3:0]        cmd;
    } trk_t;

    trk_t trk_d, trk_q;

    always_comb begin
        trk_d = trk_q;
        if (upd) begin
            trk_d.addr = cur_addr;
            trk_d.cmd  = cur_cmd;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            trk_q.addr <= '1;
            trk_q.cmd  <= CMD_INVALID;
        end else begin
            trk_q <= trk_d;
        end
    end

    assign differ = (cur_addr != trk_q.addr) || (cur_cmd != trk_q.cmd);
endmodule

// File: rtl/aux_i2c_bridge.sv
module aux_i2c_bridge
    import aux_bridge_pkg::*;
#(
    parameter int ADDR_W = 20,
    parameter int LEN_W  = 5,
    parameter int I2C_AW = 7
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic [3:0]        req_cmd,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [LEN_W-1:0]  req_len,
    output logic              rsp_valid,
    output logic [1:0]        rsp_code,
    output logic [LEN_W-1:0]  buf_idx,
    input  logic [7:0]        buf_rdata,
    output logic              buf_wr,
    output logic [7:0]        buf_wdata,
    output logic              reg_req,
    output logic              reg_we,
    output logic [ADDR_W-1:0] reg_addr,
    output logic [7:0]        reg_wdata,
    input  logic [7:0]        reg_rdata,
    input  logic              reg_err,
    output logic              i2c_req,
    output logic [1:0]        i2c_op,
    output logic [I2C_AW-1:0] i2c_addr,
    output logic              i2c_rd,
    output logic [7:0]        i2c_wdata,
    input  logic              i2c_done,
    input  logic              i2c_nak,
    input  logic [7:0]        i2c_rdata,
    output logic              link_open
);
    typedef struct packed {
        state_e            st;
        logic [3:0]        cmd;
        logic [ADDR_W-1:0] addr;
        logic [LEN_W-1:0]  len;
        logic [LEN_W-1:0]  idx;
        rsp_e              code;
        logic              open;
    } ctx_t;

    localparam ctx_t CTX_RST = '{ST_IDLE, 4'h0, '0, '0, '0, RSP_ACK, 1'b0};

    ctx_t    ctx_d, ctx_q;
    kind_e   kind;
    logic    rd;
    logic    differ;
    logic    trk_upd;
    i2c_op_e op;

    aux_cmd_decode u_dec (
        .cmd     (ctx_q.cmd),
        .kind    (kind),
        .is_read (rd)
    );

    aux_open_track #(.ADDR_W(ADDR_W)) u_trk (
        .clk      (clk),
        .rst_n    (rst_n),
        .upd      (trk_upd),
        .cur_addr (ctx_q.addr),
        .cur_cmd  (ctx_q.cmd),
        .differ   (differ)
    );

    always_comb begin
        ctx_d   = ctx_q;
        trk_upd = 1'b0;
        i2c_req = 1'b0;
        op      = OP_START;
        reg_req = 1'b0;
        buf_wr  = 1'b0;
        unique case (ctx_q.st)
            ST_IDLE: begin
                if (req_valid) begin
                    ctx_d.cmd  = req_cmd;
                    ctx_d.addr = req_addr;
                    ctx_d.len  = req_len;
                    ctx_d.idx  = '0;
                    ctx_d.st   = ST_DISPATCH;
                end
            end
            ST_DISPATCH: begin
                unique case (kind)
                    K_BAD: begin
                        ctx_d.code = RSP_NACK;
                        ctx_d.st   = ST_REPLY;
                    end
                    K_NATIVE: ctx_d.st = ST_NATIVE;
                    K_PLAIN:  ctx_d.st = ctx_q.open ? ST_PRE_END : ST_START;
                    K_OPEN: begin
                        if (!ctx_q.open) begin
                            ctx_d.st = ST_START;
                        end else if (differ) begin
                            ctx_d.st = ST_PRE_END;
                        end else begin
                            trk_upd  = 1'b1;
                            ctx_d.st = ST_XFER;
                        end
                    end
                endcase
            end
            ST_NATIVE: begin
                if (ctx_q.idx == ctx_q.len) begin
                    ctx_d.code = RSP_ACK;
                    ctx_d.st   = ST_REPLY;
                end else begin
                    reg_req = 1'b1;
                    if (reg_err) begin
                        ctx_d.code = RSP_NACK;
                        ctx_d.st   = ST_REPLY;
                    end else begin
                        buf_wr    = rd;
                        ctx_d.idx = ctx_q.idx + 1'b1;
                    end
                end
            end
            ST_PRE_END: begin
                i2c_req = 1'b1;
                op      = OP_STOP;
                if (i2c_done) begin
                    ctx_d.open = 1'b0;
                    ctx_d.st   = ST_START;
                end
            end
            ST_START: begin
                i2c_req = 1'b1;
                op      = OP_START;
                if (i2c_done) begin
                    if (i2c_nak) begin
                        ctx_d.code = RSP_I2C_NACK;
                        ctx_d.st   = ST_REPLY;
                    end else begin
                        ctx_d.open = 1'b1;
                        trk_upd    = (kind == K_OPEN);
                        ctx_d.st   = ST_XFER;
                    end
                end
            end
            ST_XFER: begin
                if (ctx_q.idx == ctx_q.len) begin
                    ctx_d.code = RSP_I2C_ACK;
                    ctx_d.st   = (kind == K_PLAIN) ? ST_POST_END : ST_REPLY;
                end else begin
                    i2c_req = 1'b1;
                    op      = rd ? OP_RECV : OP_SEND;
                    if (i2c_done) begin
                        if (i2c_nak) begin
                            ctx_d.code = RSP_I2C_NACK;
                            ctx_d.st   = ST_POST_END;
                        end else begin
                            buf_wr    = rd;
                            ctx_d.idx = ctx_q.idx + 1'b1;
                        end
                    end
                end
            end
            ST_POST_END: begin
                i2c_req = 1'b1;
                op      = OP_STOP;
                if (i2c_done) begin
                    ctx_d.open = 1'b0;
                    ctx_d.st   = ST_REPLY;
                end
            end
            ST_REPLY: ctx_d.st = ST_IDLE;
            default:  ctx_d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctx_q <= CTX_RST;
        end else begin
            ctx_q <= ctx_d;
        end
    end

    assign req_ready = (ctx_q.st == ST_IDLE);
    assign rsp_valid = (ctx_q.st == ST_REPLY);
    assign rsp_code  = ctx_q.code;
    assign buf_idx   = ctx_q.idx;
    assign buf_wdata = (kind == K_NATIVE) ? reg_rdata : i2c_rdata;
    assign reg_we    = !rd;
    assign reg_addr  = ctx_q.addr + ADDR_W'(ctx_q.idx);
    assign reg_wdata = buf_rdata;
    assign i2c_op    = op;
    assign i2c_addr  = ctx_q.addr[I2C_AW-1:0];
    assign i2c_rd    = rd;
    assign i2c_wdata = buf_rdata;
    assign link_open = ctx_q.open;

    // R3: the reply lasts one cycle and the bridge is ready right after
    p_rsp_pulse_r3: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |=> (!rsp_valid && req_ready));

    // R2: an unsupported code is answered with NACK on the next cycle
    p_bad_cmd_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (ctx_q.st == ST_DISPATCH && kind == K_BAD) |=>
            (rsp_valid && rsp_code == RSP_NACK));

    // R5: a refused register access ends the request with NACK
    p_native_err_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_req && reg_err) |=> (rsp_valid && rsp_code == RSP_NACK));

    // R10: operation held stable until the port completes it
    p_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (i2c_req && !i2c_done) |=> (i2c_req && $stable(i2c_op)));

    // R10: no START on an open link
    p_no_start_open_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (i2c_req && i2c_op == OP_START) |-> !link_open);

    // R10: register space and I2C port are never used together
    p_excl_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !(reg_req && i2c_req));

    // R7: a completed STOP closes the link
    p_stop_closes_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (i2c_req && i2c_op == OP_STOP && i2c_done) |=> !link_open);

    // R6: a plain request never leaves the link open
    p_plain_closed_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && kind == K_PLAIN) |-> !link_open);

    // R9: a successful open-ended request keeps the link open
    p_open_kept_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && kind == K_OPEN && rsp_code == RSP_I2C_ACK) |-> link_open);

endmodule

// File: tb/test_aux_i2c_bridge.sv
module test_aux_i2c_bridge;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic        req_ready;
    logic [3:0]  req_cmd = '0;
    logic [19:0] req_addr = '0;
    logic [4:0]  req_len = '0;
    logic        rsp_valid;
    logic [1:0]  rsp_code;
    logic [4:0]  buf_idx;
    logic [7:0]  buf_rdata;
    logic        buf_wr;
    logic [7:0]  buf_wdata;
    logic        reg_req, reg_we;
    logic [19:0] reg_addr;
    logic [7:0]  reg_wdata, reg_rdata;
    logic        reg_err;
    logic        i2c_req;
    logic [1:0]  i2c_op;
    logic [6:0]  i2c_addr;
    logic        i2c_rd;
    logic [7:0]  i2c_wdata;
    logic        i2c_done;
    logic        i2c_nak;
    logic [7:0]  i2c_rdata;
    logic        link_open;

    always #5 clk = ~clk;

    aux_i2c_bridge i_aux_i2c_bridge (
        .clk(clk), .rst_n(rst_n),
        .req_valid(req_valid), .req_ready(req_ready), .req_cmd(req_cmd),
        .req_addr(req_addr), .req_len(req_len),
        .rsp_valid(rsp_valid), .rsp_code(rsp_code),
        .buf_idx(buf_idx), .buf_rdata(buf_rdata), .buf_wr(buf_wr), .buf_wdata(buf_wdata),
        .reg_req(reg_req), .reg_we(reg_we), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
        .reg_rdata(reg_rdata), .reg_err(reg_err),
        .i2c_req(i2c_req), .i2c_op(i2c_op), .i2c_addr(i2c_addr), .i2c_rd(i2c_rd),
        .i2c_wdata(i2c_wdata), .i2c_done(i2c_done), .i2c_nak(i2c_nak),
        .i2c_rdata(i2c_rdata), .link_open(link_open)
    );

    // buffer, register space and I2C target models
    logic [7:0] wbuf [16];
    logic [7:0] rbuf [16];
    logic [7:0] mem  [16];
    logic [7:0] sent [32];
    int n_start = 0, n_stop = 0, n_bytes = 0, n_reg = 0, n_sent = 0;
    logic       done_q = 1'b0;
    logic [7:0] rpos = '0;

    assign buf_rdata = wbuf[buf_idx[3:0]];
    assign reg_err   = (reg_addr[19:4] != 16'h0010);
    assign reg_rdata = mem[reg_addr[3:0]];
    assign i2c_done  = done_q;
    assign i2c_rdata = 8'hC0 + rpos;
    // targets 0x50..0x57 answer; the data byte 0xEE is refused
    assign i2c_nak   = (i2c_op == 2'd0) ? (i2c_addr[6:3] != 4'hA) :
                       (i2c_op == 2'd1) ? (i2c_wdata == 8'hEE) : 1'b0;

    always @(posedge clk) begin
        if (!rst_n) begin
            done_q <= 1'b0;
        end else begin
            done_q <= i2c_req && !done_q;
            if (i2c_req && done_q) begin
                case (i2c_op)
                    2'd0: begin n_start <= n_start + 1; rpos <= '0; end
                    2'd1: begin n_bytes <= n_bytes + 1; sent[n_sent[4:0]] <= i2c_wdata; n_sent <= n_sent + 1; end
                    2'd2: begin n_bytes <= n_bytes + 1; rpos <= rpos + 1'b1; end
                    default: n_stop <= n_stop + 1;
                endcase
            end
            if (reg_req) begin
                n_reg <= n_reg + 1;
                if (reg_we && !reg_err) mem[reg_addr[3:0]] <= reg_wdata;
            end
            if (buf_wr) rbuf[buf_idx[3:0]] <= buf_wdata;
        end
    end

    int checks = 0;
    int errors = 0;

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    logic [1:0] last_code;
    int d_start, d_stop, d_bytes, d_reg;

    task automatic do_req(input logic [3:0] cmd, input logic [19:0] addr,
                          input logic [4:0] len, input logic [7:0] seed);
        int s0, p0, b0, g0;
        int guard;
        for (int i = 0; i < 16; i++) wbuf[i] = seed + 8'(i);
        @(negedge clk);
        guard = 0;
        while (!req_ready && guard < 2000) begin @(negedge clk); guard++; end
        s0 = n_start; p0 = n_stop; b0 = n_bytes; g0 = n_reg;
        req_cmd = cmd; req_addr = addr; req_len = len; req_valid = 1'b1;
        @(negedge clk);
        req_valid = 1'b0;
        guard = 0;
        while (!rsp_valid && guard < 2000) begin @(negedge clk); guard++; end
        chk(rsp_valid, "R3 reply timeout", 0, 1);
        last_code = rsp_code;
        d_start = n_start - s0; d_stop = n_stop - p0;
        d_bytes = n_bytes - b0; d_reg = n_reg - g0;
        @(negedge clk);
        chk(!rsp_valid && req_ready, "R3 pulse", int'(rsp_valid), 0);
    endtask

    typedef struct packed {
        logic [3:0]  cmd;
        logic [19:0] addr;
        logic [4:0]  len;
        logic [7:0]  seed;
        logic [1:0]  code;
        logic [3:0]  starts;
        logic [3:0]  stops;
        logic [4:0]  bytes;
        logic [4:0]  regs;
        logic        open;
    } vec_t;

    localparam int NV = 19;
    localparam vec_t VECS [NV] = '{
        '{4'h0, 20'h50,  5'd2, 8'h10, 2'b10, 4'd1, 4'd1, 5'd2, 5'd0, 1'b0}, // R6 R7 plain write
        '{4'h0, 20'h33,  5'd2, 8'h10, 2'b11, 4'd1, 4'd0, 5'd0, 5'd0, 1'b0}, // R6 start refused
        '{4'h0, 20'h50,  5'd4, 8'hEC, 2'b11, 4'd1, 4'd1, 5'd3, 5'd0, 1'b0}, // R7 byte refused
        '{4'h4, 20'h50,  5'd1, 8'h20, 2'b10, 4'd1, 4'd0, 5'd1, 5'd0, 1'b1}, // R8 idle start
        '{4'h4, 20'h50,  5'd2, 8'h30, 2'b10, 4'd0, 4'd0, 5'd2, 5'd0, 1'b1}, // R8 continue
        '{4'h5, 20'h50,  5'd2, 8'h00, 2'b10, 4'd1, 4'd1, 5'd2, 5'd0, 1'b1}, // R8 command change
        '{4'h5, 20'h51,  5'd1, 8'h00, 2'b10, 4'd1, 4'd1, 5'd1, 5'd0, 1'b1}, // R8 address change
        '{4'h2, 20'h50,  5'd1, 8'h00, 2'b01, 4'd0, 4'd0, 5'd0, 5'd0, 1'b1}, // R2 bad, link kept
        '{4'h8, 20'h100, 5'd3, 8'h40, 2'b00, 4'd0, 4'd0, 5'd0, 5'd3, 1'b1}, // R4 native write
        '{4'h1, 20'h50,  5'd1, 8'h00, 2'b10, 4'd1, 4'd2, 5'd1, 5'd0, 1'b0}, // R6 plain on open link
        '{4'h4, 20'h50,  5'd0, 8'h00, 2'b10, 4'd1, 4'd0, 5'd0, 5'd0, 1'b1}, // R9 len 0
        '{4'h4, 20'h50,  5'd3, 8'hEC, 2'b11, 4'd0, 4'd1, 5'd3, 5'd0, 1'b0}, // R9 byte refused
        '{4'h4, 20'h33,  5'd1, 8'h00, 2'b11, 4'd1, 4'd0, 5'd0, 5'd0, 1'b0}, // R9 start refused
        '{4'h8, 20'h10E, 5'd3, 8'h60, 2'b01, 4'd0, 4'd0, 5'd0, 5'd3, 1'b0}, // R5 third refused
        '{4'h9, 20'h100, 5'd3, 8'h00, 2'b00, 4'd0, 4'd0, 5'd0, 5'd3, 1'b0}, // R4 native read
        '{4'h9, 20'h100, 5'd0, 8'h00, 2'b00, 4'd0, 4'd0, 5'd0, 5'd0, 1'b0}, // R4 len 0
        '{4'hC, 20'h100, 5'd1, 8'h00, 2'b01, 4'd0, 4'd0, 5'd0, 5'd0, 1'b0}, // R2 bad
        '{4'h1, 20'h57,  5'd0, 8'h00, 2'b10, 4'd1, 4'd1, 5'd0, 5'd0, 1'b0}, // R7 len 0
        '{4'hA, 20'h100, 5'd1, 8'h00, 2'b01, 4'd0, 4'd0, 5'd0, 5'd0, 1'b0}  // R2 bad
    };

    task automatic summary();
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog actual=0 expected=1");
        summary();
    end

    initial begin
        for (int i = 0; i < 16; i++) mem[i] = '0;
        repeat (3) @(negedge clk);
        // R1 reset state
        chk(req_ready && !rsp_valid && !link_open && !i2c_req && !reg_req,
            "R1 in reset", int'({req_ready, rsp_valid, link_open, i2c_req, reg_req}), 16);
        rst_n = 1'b1;
        @(negedge clk);
        chk(req_ready && !rsp_valid && !link_open && !i2c_req && !reg_req,
            "R1 after reset", int'({req_ready, rsp_valid, link_open, i2c_req, reg_req}), 16);

        for (int v = 0; v < NV; v++) begin
            do_req(VECS[v].cmd, VECS[v].addr, VECS[v].len, VECS[v].seed);
            chk(last_code == VECS[v].code, $sformatf("R3 vec%0d code", v), last_code, VECS[v].code);
            chk(d_start == int'(VECS[v].starts), $sformatf("R8 vec%0d starts", v), d_start, VECS[v].starts);
            chk(d_stop == int'(VECS[v].stops), $sformatf("R7 vec%0d stops", v), d_stop, VECS[v].stops);
            chk(d_bytes == int'(VECS[v].bytes), $sformatf("R7 vec%0d bytes", v), d_bytes, VECS[v].bytes);
            chk(d_reg == int'(VECS[v].regs), $sformatf("R4 vec%0d reg accesses", v), d_reg, VECS[v].regs);
            chk(link_open == VECS[v].open, $sformatf("R9 vec%0d link", v), link_open, VECS[v].open);
        end

        // R4 native read returns written bytes in order
        do_req(4'h9, 20'h100, 5'd3, 8'h00);
        for (int i = 0; i < 3; i++)
            chk(rbuf[i] == 8'h40 + 8'(i), "R4 read data", rbuf[i], 8'h40 + i);

        // R5 bytes written before the refused access remain
        do_req(4'h9, 20'h10E, 5'd2, 8'h00);
        chk(rbuf[0] == 8'h60 && rbuf[1] == 8'h61, "R5 partial write",
            int'({rbuf[0], rbuf[1]}), 16'h6061);

        // R7 plain write sends buffer bytes in order
        n_sent = 0;
        do_req(4'h0, 20'h52, 5'd3, 8'h77);
        for (int i = 0; i < 3; i++)
            chk(sent[i] == 8'h77 + 8'(i), "R7 sent data", sent[i], 8'h77 + i);

        // R9 open-ended read stores received bytes
        do_req(4'h5, 20'h52, 5'd3, 8'h00);
        for (int i = 0; i < 3; i++)
            chk(rbuf[i] == 8'hC0 + 8'(i), "R9 read data", rbuf[i], 8'hC0 + i);
        chk(link_open, "R9 link kept", link_open, 1);

        // R1 reset while a transfer is open
        rst_n = 1'b0;
        @(negedge clk);
        @(negedge clk);
        chk(!link_open && req_ready && !rsp_valid, "R1 reset clears link",
            int'({link_open, req_ready, rsp_valid}), 2);
        rst_n = 1'b1;
        @(negedge clk);

        // R8 after reset the open-ended request starts fresh
        do_req(4'h5, 20'h52, 5'd1, 8'h00);
        chk(d_start == 1 && d_stop == 0, "R8 start after reset", d_start * 16 + d_stop, 16);

        summary();
    end

endmodule